// File: doc/BRIEF.md
# Sample-Rate Safety Peak Limiter

This block is a digital hard-knee peak limiter for a mono stream of signed 12-bit audio samples. A free-running divider makes one sample strobe every 64 system clocks. On each strobe the block captures the sample on its input. On the next strobe it puts out a limited version of the previous sample. When the sample's magnitude is at or below a fixed threshold, the sample passes through unchanged. Above the threshold, the part of the magnitude beyond the threshold is reduced at a fixed 20:1 ratio. The sign of the sample is then restored.

With every output sample the block also reports how much it removed, as an unsigned gain-reduction amount. It drives an active-low flag that is low for the whole sample period whenever that amount is nonzero. A downstream adaptive controller can use the amount and the flag to decide whether its own compression settings need to change. The threshold is a build-time magnitude code that stands in for a +3 dBu level. The division by 20 uses a reciprocal multiply with rounding.

Top module: `lim_peak_limiter`

## Requirements
- R1: While `rst_n` is low, and after it is released, `sample_out` and `gr_amt` read 0 and `gr_n` reads 1 until the first strobe updates them.
- R2: `sample_stb` is high for exactly one clock in every 64 clocks. The first pulse comes 63 clocks after reset release.
- R3: A sample present on `sample_in` at a strobe edge appears on the outputs right after the next strobe edge. The outputs hold their values for the whole 64-clock period in between.
- R4: A sample whose magnitude is at or below the threshold THRESH (default 1024) is passed to `sample_out` unchanged, with `gr_amt` = 0.
- R5: For magnitude m > THRESH, the output magnitude equals THRESH + (m − THRESH)/20, rounded to nearest, within 1 LSB.
- R6: `gr_amt` (unsigned 12-bit) equals the input magnitude minus the output magnitude.
- R7: `gr_n` is low for the whole sample period exactly when that sample's magnitude exceeds THRESH, and high otherwise.
- R8: Samples are 12-bit two's complement. A negative input gives a negative output of the same limited magnitude, including the full-scale code −2048 (0x800).
- R9: At the knee, magnitude THRESH passes with `gr_n` high. Magnitude THRESH+1 gives output magnitude THRESH, `gr_amt` = 1 and `gr_n` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sample_in | input | 12 | Signed input sample, captured on a strobe |
| sample_stb | output | 1 | One-clock sample strobe, once per 64 clocks |
| sample_out | output | 12 | Signed limited sample |
| gr_amt | output | 12 | Unsigned gain-reduction amount for the current output sample |
| gr_n | output | 1 | Low while the current output sample is being reduced |

## Verification
The assertions watch properties that hold on every cycle:
- the strobe spacing and its single-cycle width;
- outputs that hold between strobes;
- the output magnitude never exceeding the input magnitude, and staying within the 20:1 bound;
- the flag and the amount agreeing, and the output sign following the captured sample.

Only the directed scenarios can show that the limited magnitude matches the rounded 20:1 law, that the knee sits at exactly THRESH, that the one-strobe latency pairs each output with the right input, and that the full-scale negative code is handled.

// File: rtl/lim_pkg.sv
package lim_pkg;
  localparam int SAMP_W_DEF    = 12;
  localparam int DIV_RATIO_DEF = 64;
  localparam int THRESH_DEF    = 1024;
  localparam int RATIO_DEF     = 20;
  localparam int FRAC_W_DEF    = 16;

  // Reciprocal of the ratio in FRAC_W fraction bits, rounded up.
  function automatic int recip(input int ratio, input int frac_w);
    return ((1 << frac_w) + ratio - 1) / ratio;
  endfunction
endpackage

// File: rtl/lim_strobe_div.sv
module lim_strobe_div #(
  parameter int DIV_RATIO = lim_pkg::DIV_RATIO_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic stb
);
  localparam int CNT_W = $clog2(DIV_RATIO);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign stb = (cnt_q == LAST);

  // Checker: count clocks between strobes independently of the divider.
  logic [CNT_W:0] gap_q;
  logic           seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (stb) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  assert_stb_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && seen_q) |-> (gap_q == (CNT_W+1)'(DIV_RATIO - 1)));
  assert_stb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);
endmodule

// File: rtl/lim_gain_core.sv
module lim_gain_core #(
  parameter int SAMP_W = lim_pkg::SAMP_W_DEF,
  parameter int THRESH = lim_pkg::THRESH_DEF,
  parameter int RATIO  = lim_pkg::RATIO_DEF,
  parameter int FRAC_W = lim_pkg::FRAC_W_DEF
) (
  input  logic [SAMP_W-1:0] smp_i,
  output logic [SAMP_W-1:0] smp_o,
  output logic [SAMP_W-1:0] red_o
);
  localparam int RECIP  = lim_pkg::recip(RATIO, FRAC_W);
  localparam int PROD_W = SAMP_W + FRAC_W + 1;
  localparam logic [SAMP_W-1:0] THR = SAMP_W'(THRESH);
  localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC_W - 1);

  logic              neg;
  logic [SAMP_W-1:0] mag_in, excess, quot, mag_out;
  logic [PROD_W-1:0] prod;

  always_comb begin
    neg    = smp_i[SAMP_W-1];
    mag_in = neg ? (~smp_i + 1'b1) : smp_i;
    excess = (mag_in > THR) ? (mag_in - THR) : '0;
    prod   = PROD_W'(excess) * PROD_W'(RECIP) + HALF;
    quot   = prod[FRAC_W +: SAMP_W];
    mag_out = (mag_in > THR) ? (THR + quot) : mag_in;
    red_o  = mag_in - mag_out;
    smp_o  = neg ? (~mag_out + 1'b1) : mag_out;
  end

  // R5/R6: limiting never increases the magnitude.
  always_comb begin
    assert_no_gain_R6: assert (mag_out <= mag_in);
  end
endmodule

// File: rtl/lim_peak_limiter.sv
module lim_peak_limiter #(
  parameter int SAMP_W    = lim_pkg::SAMP_W_DEF,
  parameter int DIV_RATIO = lim_pkg::DIV_RATIO_DEF,
  parameter int THRESH    = lim_pkg::THRESH_DEF,
  parameter int RATIO     = lim_pkg::RATIO_DEF,
  parameter int FRAC_W    = lim_pkg::FRAC_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SAMP_W-1:0] sample_in,
  output logic              sample_stb,
  output logic [SAMP_W-1:0] sample_out,
  output logic [SAMP_W-1:0] gr_amt,
  output logic              gr_n
);
  localparam int FULL   = 1 << (SAMP_W - 1);
  localparam int MAXOUT = THRESH + (FULL - THRESH + RATIO - 1) / RATIO + 1;

  logic              stb;
  logic [SAMP_W-1:0] cap_q, cap_d;
  logic [SAMP_W-1:0] out_q, out_d, red_q, red_d;
  logic              grn_q, grn_d;
  logic [SAMP_W-1:0] core_smp, core_red;

  lim_strobe_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk (clk),
    .rst_n (rst_n),
    .stb (stb)
  );

  lim_gain_core #(
    .SAMP_W(SAMP_W), .THRESH(THRESH), .RATIO(RATIO), .FRAC_W(FRAC_W)
  ) u_core (
    .smp_i (cap_q),
    .smp_o (core_smp),
    .red_o (core_red)
  );

  always_comb begin
    cap_d = cap_q;
    out_d = out_q;
    red_d = red_q;
    grn_d = grn_q;
    if (stb) begin
      cap_d = sample_in;
      out_d = core_smp;
      red_d = core_red;
      grn_d = (core_red == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      out_q <= '0;
      red_q <= '0;
      grn_q <= 1'b1;
    end else begin
      cap_q <= cap_d;
      out_q <= out_d;
      red_q <= red_d;
      grn_q <= grn_d;
    end
  end

  assign sample_stb = stb;
  assign sample_out = out_q;
  assign gr_amt     = red_q;
  assign gr_n       = grn_q;

  // Checker-side magnitude of the output.
  logic [SAMP_W-1:0] out_mag;
  assign out_mag = out_q[SAMP_W-1] ? (~out_q + 1'b1) : out_q;

  assert_hold_between_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb) |-> ($stable(sample_out) && $stable(gr_amt) && $stable(gr_n)));
  assert_flag_matches_amount_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gr_n == (gr_amt == '0));
  assert_knee_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !gr_n |-> (out_mag >= SAMP_W'(THRESH)));
  assert_out_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(out_mag) <= MAXOUT));
  assert_sign_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && cap_q != '0) |=> (sample_out[SAMP_W-1] == $past(cap_q[SAMP_W-1])));
endmodule

// File: tb/tb_lim_peak_limiter.sv
`timescale 1ns/1ps
module tb_lim_peak_limiter;
  localparam int W = 12;
  localparam int T = 1024;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] sample_in = '0;
  logic         sample_stb;
  logic [W-1:0] sample_out, gr_amt;
  logic         gr_n;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  lim_peak_limiter dut (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in),
    .sample_stb(sample_stb), .sample_out(sample_out),
    .gr_amt(gr_amt), .gr_n(gr_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mag_of(input logic [W-1:0] v);
    return (v[W-1]) ? (1 << W) - int'(v) : int'(v);
  endfunction

  function automatic int ref_mag(input int m);
    if (m <= T) return m;
    return T + (m - T + 10) / 20;
  endfunction

  task automatic wait_stb();
    do @(negedge clk); while (!sample_stb);
  endtask

  task automatic send(input logic [W-1:0] x);
    wait_stb();
    sample_in = x;
    @(posedge clk);
  endtask

  // Push x through and check its output in the period after the next strobe.
  task automatic run_sample(input string tag, input logic [W-1:0] x);
    int mi, mo, rm, d;
    send(x);
    wait_stb();
    @(negedge clk);
    mi = mag_of(x);
    mo = mag_of(sample_out);
    rm = ref_mag(mi);
    d  = (mo > rm) ? mo - rm : rm - mo;
    chk({tag, " R5 mag within 1 LSB"}, (d <= 1) ? 1 : 0, 1);
    chk({tag, " R6 gr_amt"}, int'(gr_amt), mi - mo);
    chk({tag, " R7 flag"}, int'(gr_n), (mi > T) ? 0 : 1);
    if (x != '0) chk({tag, " R8 sign"}, int'(sample_out[W-1]), int'(x[W-1]));
    if (mi <= T) chk({tag, " R4 passthrough"}, int'(sample_out), int'(x));
  endtask

  task automatic test_reset();
    chk("R1 out in reset", int'(sample_out), 0);
    chk("R1 gr_n in reset", int'(gr_n), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out after release", int'(sample_out), 0);
    chk("R1 gr_amt after release", int'(gr_amt), 0);
    chk("R1 gr_n after release", int'(gr_n), 1);
  endtask

  task automatic test_strobe();
    int n = 1, first = 0, gap = 0;
    // rst released at a negedge; count negedges until first strobe.
    while (!sample_stb) begin @(negedge clk); n++; end
    first = n;
    chk("R2 first strobe delay", first, 63);
    @(negedge clk);
    chk("R2 strobe one clock wide", int'(sample_stb), 0);
    gap = 1;
    while (!sample_stb) begin @(negedge clk); gap++; end
    chk("R2 strobe period", gap, 64);
  endtask

  task automatic test_latency();
    logic [W-1:0] a = 12'd300, b = 12'd1800;
    send(a);
    send(b);
    @(negedge clk);
    chk("R3 first output is A", int'(sample_out), 300);
    repeat (40) @(negedge clk);
    chk("R3 held mid-period", int'(sample_out), 300);
    chk("R3 flag held", int'(gr_n), 1);
    wait_stb();
    chk("R3 still A before edge", int'(sample_out), 300);
    @(negedge clk);
    chk("R3 B after next strobe", mag_of(sample_out), ref_mag(1800));
    chk("R7 flag low for B", int'(gr_n), 0);
    repeat (50) @(negedge clk);
    chk("R7 flag low whole period", int'(gr_n), 0);
  endtask

  task automatic test_knee();
    run_sample("knee+T", 12'(T));
    run_sample("knee+T+1", 12'(T + 1));
    chk("R9 out at T+1", int'(sample_out), T);
    chk("R9 gr_amt at T+1", int'(gr_amt), 1);
    run_sample("knee-T", 12'(-T));
    chk("R9 flag at -T", int'(gr_n), 1);
  endtask

  task automatic test_patterns();
    run_sample("zero", 12'd0);
    run_sample("small", 12'd100);
    run_sample("neg small", 12'(-77));
    run_sample("max pos", 12'd2047);
    chk("R5 exact at 2047", int'(sample_out), 1075);
    run_sample("full neg", 12'h800);
    chk("R8 full neg out", int'(sample_out), (1 << W) - 1075);
    chk("R6 full neg gr", int'(gr_amt), 973);
    run_sample("neg above", 12'(-1500));
    run_sample("tie", 12'(T + 10));
    run_sample("above 40", 12'(T + 40));
    chk("R5 exact at T+40", int'(sample_out), T + 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_strobe();
    test_latency();
    test_knee();
    test_patterns();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule